// File: doc/BRIEF.md
# Redriver Power Mode Controller

This block chooses the operating mode of a multi-lane video link redriver: power-down, standby or active. It reads a chip enable, a hot-plug-detect input and a clock-lane signal-detect flag. It also reads three configuration bits: a forced power-down, a standby bypass, and a bypass of the hot-plug power-down. From these it drives the hot-plug output and its output enable, a receiver enable mask, a transmitter enable mask, the side-channel (DDC) enable and a two-bit mode code.

Two separate mechanisms move the block between modes. A debounced hot-plug level moves it into and out of power-down. A debounced clock-lane activity indication moves it between standby and active. All debounce and entry windows are counters whose lengths are parameters.

In standby only the clock-lane receiver stays on, so that the block can watch for traffic. When traffic has been present long enough, every lane's receiver and transmitter is switched on.

Top module: `redrv_pwr_ctrl`

## Requirements
- R1: With `en_i` low, every enable output and `hpd_oe_o` are 0 in the same cycle. `state_o` reads 0 (power-down) after the next rising edge.
- R2: With `en_i` high and `pd_force_i` high, `state_o` is 0 after the next edge. In power-down with `en_i` high, `hpd_oe_o`=1, `hpd_o`=0, `ddc_en_o`=1 and both masks are 0.
- R3: In standby or active, with `hpd_bypass_i` clear, `hpd_i` sampled low on HPD_LOW_CYC consecutive edges makes `state_o` read 0 after the edge that follows.
- R4: Power-down is left only after `hpd_i` (or `hpd_bypass_i`) has been sampled high on HPD_HIGH_CYC consecutive edges with `en_i` high and `pd_force_i` low. The move happens on the edge that follows.
- R5: In standby (`state_o`=1), `rx_en_o` is 1 (bit 0 is the clock lane), `tx_en_o` is 0 and `ddc_en_o` is 1.
- R6: In active mode, `sig_det_i` sampled low on IDLE_CYC consecutive edges returns the block to standby on the following edge, unless `sby_dis_i` is set.
- R7: In standby, `sig_det_i` sampled high on SIGDET_CYC consecutive edges moves the block to active on the following edge. A shorter pulse leaves it in standby.
- R8: With `sby_dis_i` set and no power-down cause, the block goes to active and stays there regardless of `sig_det_i`.
- R9: In standby and active, `hpd_o` equals `hpd_i`. With `hpd_bypass_i` set, `hpd_o` is 1 and a low `hpd_i` never causes power-down.
- R10: Each window restarts when its condition breaks. A glitch shorter than its window changes no state.
- R11: After reset `state_o` is 0. The mode codes are 0 power-down, 1 standby and 2 active. In active both masks are all ones and `ddc_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Chip enable |
| hpd_i | input | 1 | Hot-plug-detect input |
| sig_det_i | input | 1 | Clock-lane signal present |
| pd_force_i | input | 1 | Configuration: force power-down |
| sby_dis_i | input | 1 | Configuration: bypass standby |
| hpd_bypass_i | input | 1 | Configuration: hot-plug power-down bypass |
| hpd_o | output | 1 | Hot-plug output level |
| hpd_oe_o | output | 1 | Hot-plug output drive enable (0 = high-impedance) |
| rx_en_o | output | DATA_LANES+1 | Receiver enables, bit 0 clock lane |
| tx_en_o | output | DATA_LANES+1 | Transmitter enables, bit 0 clock lane |
| ddc_en_o | output | 1 | Side-channel enable |
| state_o | output | 2 | Mode code |

## Verification
The bench injects glitches one cycle shorter than each window. A design that failed to restart its counters would then change mode early. It lets each condition last exactly its window, so an off-by-one counter shows up as a transition one cycle early or late. It also holds `sig_det_i` low while the standby bypass is set, and holds `hpd_i` low while the hot-plug bypass is set. A decoder with wrong priority would fall back to standby or power-down in those cases. Finally it drops `en_i` while active, where a design that only looked at the registered state would leave the hot-plug output driven for one cycle.

// File: rtl/redrv_pwr_pkg.sv
package redrv_pwr_pkg;
  typedef enum logic [1:0] {
    PM_DOWN = 2'd0,
    PM_STBY = 2'd1,
    PM_ACT  = 2'd2
  } pm_state_e;

  localparam int unsigned N_TMR = 4;
  localparam int unsigned T_HLO = 0;
  localparam int unsigned T_HHI = 1;
  localparam int unsigned T_IDL = 2;
  localparam int unsigned T_SIG = 3;
endpackage

// File: rtl/redrv_hold_timer.sv
module redrv_hold_timer #(
  parameter int unsigned CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  output logic done_o
);
  localparam int unsigned W = $clog2(CYC + 1);
  localparam logic [W-1:0] LIM = W'(CYC);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!cond_i)       cnt_q <= '0;
    else if (cnt_q != LIM)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIM);

  a_r10_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_i |=> (cnt_q == '0));
  a_r10_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);
endmodule

// File: rtl/redrv_pwr_fsm.sv
module redrv_pwr_fsm
  import redrv_pwr_pkg::*;
#(
  parameter int unsigned HPD_LOW_CYC  = 12,
  parameter int unsigned HPD_HIGH_CYC = 8,
  parameter int unsigned IDLE_CYC     = 5,
  parameter int unsigned SIGDET_CYC   = 6
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      hpd_i,
  input  logic      sig_det_i,
  input  logic      pd_force_i,
  input  logic      sby_dis_i,
  input  logic      hpd_bypass_i,
  output pm_state_e state_o
);
  localparam int unsigned TCYC [N_TMR] = '{HPD_LOW_CYC, HPD_HIGH_CYC, IDLE_CYC, SIGDET_CYC};

  pm_state_e          state_q, state_d;
  logic [N_TMR-1:0]   cond, done;
  logic               run;

  assign run = en_i && !pd_force_i;

  always_comb begin
    cond        = '0;
    cond[T_HLO] = run && !hpd_i && !hpd_bypass_i && (state_q != PM_DOWN);
    cond[T_HHI] = run && (hpd_i || hpd_bypass_i) && (state_q == PM_DOWN);
    cond[T_IDL] = run && !sig_det_i && !sby_dis_i && (state_q == PM_ACT);
    cond[T_SIG] = run && sig_det_i && (state_q == PM_STBY);
  end

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    redrv_hold_timer #(.CYC(TCYC[g])) u_tmr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cond_i(cond[g]),
      .done_o(done[g])
    );
  end

  always_comb begin
    state_d = state_q;
    if (!run) begin
      state_d = PM_DOWN;
    end else begin
      unique case (state_q)
        PM_DOWN: if (done[T_HHI]) state_d = sby_dis_i ? PM_ACT : PM_STBY;
        PM_STBY: begin
          if (done[T_HLO])                     state_d = PM_DOWN;
          else if (sby_dis_i || done[T_SIG])   state_d = PM_ACT;
        end
        PM_ACT: begin
          if (done[T_HLO])      state_d = PM_DOWN;
          else if (done[T_IDL]) state_d = PM_STBY;
        end
        default: state_d = PM_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PM_DOWN;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  a_r1_en_low_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == PM_DOWN));
  a_r2_force_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_force_i |=> (state_q == PM_DOWN));
  a_r4_hold_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_DOWN && !done[T_HHI]) |=> (state_q == PM_DOWN));
  a_r7_hold_stby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_STBY && run && !sby_dis_i && !done[T_SIG] && !done[T_HLO])
      |=> (state_q == PM_STBY));
  a_r8_stay_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_ACT && run && sby_dis_i && !done[T_HLO]) |=> (state_q == PM_ACT));
  a_r9_bypass_no_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != PM_DOWN && run && hpd_bypass_i) |=> (state_q != PM_DOWN));
endmodule

// File: rtl/redrv_pwr_decode.sv
module redrv_pwr_decode
  import redrv_pwr_pkg::*;
#(
  parameter int unsigned DATA_LANES = 3,
  localparam int unsigned LN = DATA_LANES + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  pm_state_e     state_i,
  input  logic          en_i,
  input  logic          hpd_i,
  input  logic          hpd_bypass_i,
  output logic          hpd_o,
  output logic          hpd_oe_o,
  output logic [LN-1:0] rx_en_o,
  output logic [LN-1:0] tx_en_o,
  output logic          ddc_en_o
);
  logic up, act;

  assign up  = en_i && (state_i != PM_DOWN);
  assign act = en_i && (state_i == PM_ACT);

  assign hpd_oe_o = en_i;
  assign hpd_o    = up && (hpd_i || hpd_bypass_i);
  assign ddc_en_o = en_i;

  for (genvar l = 0; l < LN; l++) begin : g_lane
    if (l == 0) begin : g_clk
      assign rx_en_o[l] = up;
    end else begin : g_dat
      assign rx_en_o[l] = act;
    end
    assign tx_en_o[l] = act;
  end

  a_r1_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (rx_en_o == '0 && tx_en_o == '0 && !ddc_en_o && !hpd_oe_o));
  a_r5_stby_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_i == PM_STBY) |-> (rx_en_o == LN'(1) && tx_en_o == '0 && ddc_en_o));
  a_r2_down_hpd_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_i == PM_DOWN) |-> (hpd_oe_o && !hpd_o && rx_en_o == '0));
endmodule

// File: rtl/redrv_pwr_ctrl.sv
module redrv_pwr_ctrl
  import redrv_pwr_pkg::*;
#(
  parameter int unsigned DATA_LANES   = 3,
  parameter int unsigned HPD_LOW_CYC  = 12,
  parameter int unsigned HPD_HIGH_CYC = 8,
  parameter int unsigned IDLE_CYC     = 5,
  parameter int unsigned SIGDET_CYC   = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  hpd_i,
  input  logic                  sig_det_i,
  input  logic                  pd_force_i,
  input  logic                  sby_dis_i,
  input  logic                  hpd_bypass_i,
  output logic                  hpd_o,
  output logic                  hpd_oe_o,
  output logic [DATA_LANES:0]   rx_en_o,
  output logic [DATA_LANES:0]   tx_en_o,
  output logic                  ddc_en_o,
  output logic [1:0]            state_o
);
  pm_state_e st;

  redrv_pwr_fsm #(
    .HPD_LOW_CYC (HPD_LOW_CYC),
    .HPD_HIGH_CYC(HPD_HIGH_CYC),
    .IDLE_CYC    (IDLE_CYC),
    .SIGDET_CYC  (SIGDET_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .hpd_i       (hpd_i),
    .sig_det_i   (sig_det_i),
    .pd_force_i  (pd_force_i),
    .sby_dis_i   (sby_dis_i),
    .hpd_bypass_i(hpd_bypass_i),
    .state_o     (st)
  );

  redrv_pwr_decode #(.DATA_LANES(DATA_LANES)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (st),
    .en_i        (en_i),
    .hpd_i       (hpd_i),
    .hpd_bypass_i(hpd_bypass_i),
    .hpd_o       (hpd_o),
    .hpd_oe_o    (hpd_oe_o),
    .rx_en_o     (rx_en_o),
    .tx_en_o     (tx_en_o),
    .ddc_en_o    (ddc_en_o)
  );

  assign state_o = st;

  a_r11_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd3);
endmodule

// File: tb/redrv_pwr_ctrl_tb.sv
module redrv_pwr_ctrl_tb;
  localparam int DL = 3;
  localparam int LO = 12;
  localparam int HI = 8;
  localparam int ID = 5;
  localparam int SG = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 0, hpd_i = 0, sig_det_i = 0, pd_force_i = 0, sby_dis_i = 0, hpd_bypass_i = 0;
  logic hpd_o, hpd_oe_o, ddc_en_o;
  logic [DL:0] rx_en_o, tx_en_o;
  logic [1:0] state_o;

  int vectors = 0;
  int errors = 0;
  string cur_req = "R11";

  always #5 clk_i = ~clk_i;

  redrv_pwr_ctrl #(
    .DATA_LANES(DL), .HPD_LOW_CYC(LO), .HPD_HIGH_CYC(HI), .IDLE_CYC(ID), .SIGDET_CYC(SG)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .hpd_i(hpd_i), .sig_det_i(sig_det_i),
    .pd_force_i(pd_force_i), .sby_dis_i(sby_dis_i), .hpd_bypass_i(hpd_bypass_i),
    .hpd_o(hpd_o), .hpd_oe_o(hpd_oe_o), .rx_en_o(rx_en_o), .tx_en_o(tx_en_o),
    .ddc_en_o(ddc_en_o), .state_o(state_o)
  );

  // behavioural reference: mode 0 down, 1 standby, 2 active
  int m_mode = 0;
  int n_lo = 0, n_hi = 0, n_idle = 0, n_sig = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; n_lo = 0; n_hi = 0; n_idle = 0; n_sig = 0;
    end else begin
      automatic bit ok = en_i && !pd_force_i;
      automatic bit lo_ok  = n_lo == LO;
      automatic bit hi_ok  = n_hi == HI;
      automatic bit idl_ok = n_idle == ID;
      automatic bit sig_ok = n_sig == SG;
      automatic int nm = m_mode;
      if (ok && !hpd_i && !hpd_bypass_i && m_mode != 0) n_lo = (n_lo < LO) ? n_lo + 1 : LO; else n_lo = 0;
      if (ok && (hpd_i || hpd_bypass_i) && m_mode == 0) n_hi = (n_hi < HI) ? n_hi + 1 : HI; else n_hi = 0;
      if (ok && !sig_det_i && !sby_dis_i && m_mode == 2) n_idle = (n_idle < ID) ? n_idle + 1 : ID; else n_idle = 0;
      if (ok && sig_det_i && m_mode == 1) n_sig = (n_sig < SG) ? n_sig + 1 : SG; else n_sig = 0;
      if (!ok) nm = 0;
      else if (m_mode == 0) begin
        if (hi_ok) nm = sby_dis_i ? 2 : 1;
      end else if (lo_ok) nm = 0;
      else if (m_mode == 1) begin
        if (sby_dis_i || sig_ok) nm = 2;
      end else if (idl_ok) nm = 1;
      m_mode = nm;
    end
  end

  task automatic cmp(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      automatic int e_oe  = en_i ? 1 : 0;
      automatic int e_hpd = (en_i && m_mode != 0 && (hpd_i || hpd_bypass_i)) ? 1 : 0;
      automatic int e_rx  = !en_i ? 0 : (m_mode == 2) ? (1 << (DL + 1)) - 1 : (m_mode == 1) ? 1 : 0;
      automatic int e_tx  = (en_i && m_mode == 2) ? (1 << (DL + 1)) - 1 : 0;
      cmp("state", int'(state_o), m_mode);
      cmp("hpd_oe", int'(hpd_oe_o), e_oe);
      cmp("hpd", int'(hpd_o), e_hpd);
      cmp("rx_en", int'(rx_en_o), e_rx);
      cmp("tx_en", int'(tx_en_o), e_tx);
      cmp("ddc_en", int'(ddc_en_o), e_oe);
    end
  end

  task automatic run(int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic expect_state(int exp);
    #1;
    cmp("directed state", int'(state_o), exp);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    run(3);
    rst_ni = 1'b1;
    cur_req = "R11"; expect_state(0);
    // R4: leave power-down after HI high edges
    cur_req = "R4"; en_i = 1; hpd_i = 1;
    run(HI); expect_state(0);
    run(1); expect_state(1);
    // R5 standby masks; R10 short hpd glitch
    cur_req = "R5"; run(3);
    cur_req = "R10"; hpd_i = 0; run(LO - 1); hpd_i = 1; run(4); expect_state(1);
    // R7 short pulse then valid signal
    cur_req = "R7"; sig_det_i = 1; run(SG - 1); sig_det_i = 0; run(3); expect_state(1);
    sig_det_i = 1; run(SG); expect_state(1);
    run(1); expect_state(2);
    // R9 hpd follows input in active
    cur_req = "R9"; hpd_i = 0; run(2); hpd_i = 1; run(2);
    // R6 idle glitch then real idle
    cur_req = "R10"; sig_det_i = 0; run(ID - 1); sig_det_i = 1; run(3); expect_state(2);
    cur_req = "R6"; sig_det_i = 0; run(ID); expect_state(2);
    run(1); expect_state(1);
    // R8 standby bypass ignores signal detect
    cur_req = "R8"; sby_dis_i = 1; run(1); expect_state(2);
    run(ID * 3); expect_state(2);
    // R9 hot-plug bypass
    cur_req = "R9"; hpd_bypass_i = 1; hpd_i = 0; run(LO * 2); expect_state(2);
    // R3 hpd low debounce into power-down
    cur_req = "R3"; hpd_bypass_i = 0; run(LO); expect_state(2);
    run(1); expect_state(0);
    // R8 power-down exits straight to active with bypass
    cur_req = "R8"; hpd_i = 1; run(HI + 1); expect_state(2);
    // R2 forced power-down
    cur_req = "R2"; pd_force_i = 1; run(1); expect_state(0);
    run(HI * 2); expect_state(0);
    pd_force_i = 0; sby_dis_i = 0; run(HI + 1); expect_state(1);
    // R1 enable low from active
    sig_det_i = 1; run(SG + 1); expect_state(2);
    cur_req = "R1"; en_i = 0; #1;
    cmp("R1 hpd_oe immediate", int'(hpd_oe_o), 0);
    run(1); expect_state(0);
    run(HI * 2); expect_state(0);
    en_i = 1; run(HI + 1); expect_state(1);
    run(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule